// File: doc/BRIEF.md
# RS485 Half-Duplex Direction Controller

This block sits beside a UART transmitter on a two-wire RS485 bus and owns the transceiver's driver-enable line. When the mode is on, the line sits low so the transceiver listens. As soon as the transmit queue holds a byte, the controller raises the line. It then holds back the serializer's start for a programmable number of bit-clock ticks so the driver can settle.

The line stays high across every character of a burst. It drops only when the final stop bit has gone out and nothing else is queued. A later load of data raises it again without any software action. In this mode, the transmit-empty flag also requires the line to have been released, so software can rely on it to turn the bus around.

With the mode off, the direction output simply copies a software-controlled level, the serializer may start at will, and transmit-empty reflects only the queue and the shifter. The serializer itself is not part of this block.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset, with the mode enabled and no data queued, the direction output is low, the start permit is low and transmit-empty is high.
- R2: With the mode disabled, the direction output equals `rts_manual`, the start permit is high, and transmit-empty is high exactly when the queue is empty and the shifter is idle.
- R3: With the mode enabled and the controller idle, the direction output is low.
- R4: With the mode enabled, if `txq_nonempty` is high at a clock edge while the controller is idle, the direction output is high from that edge onward and the start permit is low.
- R5: The start permit rises on the clock edge that samples the SETTLE_TICKS-th `bit_tick` counted after the direction output rose (SETTLE_TICKS = 2 in the bench). Ticks sampled on the edge that raises the line do not count.
- R6: Once transmission is permitted, the direction output stays high until a clock edge samples `stop_done` high with `txq_nonempty` low, and it is low from that edge onward.
- R7: If `stop_done` and `txq_nonempty` are both high at the same edge, the direction output stays high with no low cycle.
- R8: After a release, a new load raises the direction output again, and the start permit goes through a new settle interval.
- R9: With the mode enabled, transmit-empty is high only when the queue is empty, the shifter is idle and the direction output is released.
- R10: Clearing the mode enable returns the controller to idle at the next edge. When the mode is re-enabled with no data queued, the direction output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_en | input | 1 | Automatic direction mode enable |
| rts_manual | input | 1 | Software direction level used while the mode is off |
| txq_nonempty | input | 1 | Transmit holding register or FIFO holds data |
| shift_busy | input | 1 | Transmit shifter is sending a character |
| stop_done | input | 1 | One-cycle strobe at the end of a character's last stop bit |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| dir_out | output | 1 | Transceiver direction, high = drive |
| tx_permit | output | 1 | Serializer may start a character |
| tx_empty | output | 1 | Transmit-empty condition |

## Verification
On every cycle, the checker confirms several properties. A queued byte seen while idle raises the line (R4). The permit is never high without the line (R5). A fall of the line is always preceded by a stop strobe with an empty queue (R6). A stop strobe with more data never opens a gap (R7). Transmit-empty never coexists with a driven line (R9). The exact tick count of the settle interval, the manual pass-through, recovery after the mode is toggled and the re-arm after a release are shown only by the bench's scenarios, which compare all three outputs each cycle against a bench-side model over constrained random traffic.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2
  } dir_state_e;
endpackage

// File: rtl/rs485_rst_sync.sv
module rs485_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/rs485_settle_timer.sv
module rs485_settle_timer #(
  parameter int SETTLE_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = (SETTLE_TICKS < 2) ? 1 : $clog2(SETTLE_TICKS);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Ticks are counted only while the settle phase runs; leaving it clears the count.
  always_comb begin
    done   = run && tick && (cnt_q == LAST);
    cnt_en = !run || tick;
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_en,
  input  logic       txq_nonempty,
  input  logic       stop_done,
  input  logic       settle_done,
  output dir_state_e state_o
);
  dir_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!mode_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (txq_nonempty) state_d = ST_SETUP;
        ST_SETUP:  if (settle_done)  state_d = ST_ACTIVE;
        // A stop strobe with more data queued keeps the line driven.
        ST_ACTIVE: if (stop_done && !txq_nonempty) state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/rs485_dir_outmux.sv
module rs485_dir_outmux
  import rs485_dir_pkg::*;
(
  input  logic       mode_en,
  input  logic       rts_manual,
  input  dir_state_e state,
  input  logic       txq_nonempty,
  input  logic       shift_busy,
  output logic       dir_out,
  output logic       tx_permit,
  output logic       tx_empty
);
  logic drained;

  always_comb begin
    drained = !txq_nonempty && !shift_busy;
    if (mode_en) begin
      dir_out   = (state != ST_IDLE);
      tx_permit = (state == ST_ACTIVE);
      tx_empty  = drained && (state == ST_IDLE);
    end else begin
      dir_out   = rts_manual;
      tx_permit = 1'b1;
      tx_empty  = drained;
    end
  end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int SETTLE_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic rts_manual,
  input  logic txq_nonempty,
  input  logic shift_busy,
  input  logic stop_done,
  input  logic bit_tick,
  output logic dir_out,
  output logic tx_permit,
  output logic tx_empty
);
  logic       rst_sync_n;
  logic       settle_done;
  dir_state_e state;

  rs485_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  rs485_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (mode_en && (state == ST_SETUP)),
    .tick  (bit_tick),
    .done  (settle_done)
  );

  rs485_dir_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mode_en      (mode_en),
    .txq_nonempty (txq_nonempty),
    .stop_done    (stop_done),
    .settle_done  (settle_done),
    .state_o      (state)
  );

  rs485_dir_outmux u_out (
    .mode_en      (mode_en),
    .rts_manual   (rts_manual),
    .state        (state),
    .txq_nonempty (txq_nonempty),
    .shift_busy   (shift_busy),
    .dir_out      (dir_out),
    .tx_permit    (tx_permit),
    .tx_empty     (tx_empty)
  );
endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_en,
  input logic txq_nonempty,
  input logic shift_busy,
  input logic stop_done,
  input logic dir_out,
  input logic tx_permit,
  input logic tx_empty
);
  p_load_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && mode_en && $past(mode_en) && !$past(dir_out) && $past(txq_nonempty)
    |-> dir_out && !tx_permit);

  p_permit_needs_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en && tx_permit |-> dir_out);

  p_release_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && mode_en && $past(mode_en) && $past(dir_out) && !dir_out
    |-> $past(stop_done) && !$past(txq_nonempty));

  p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && mode_en && $past(mode_en) && $past(dir_out)
      && $past(stop_done) && $past(txq_nonempty)
    |-> dir_out);

  p_empty_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en && tx_empty |-> !dir_out && !txq_nonempty && !shift_busy);
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .mode_en      (mode_en),
  .txq_nonempty (txq_nonempty),
  .shift_busy   (shift_busy),
  .stop_done    (stop_done),
  .dir_out      (dir_out),
  .tx_permit    (tx_permit),
  .tx_empty     (tx_empty)
);

// File: tb/rs485_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_tb_top;
  localparam int SETTLE = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_en, rts_manual, txq_nonempty, shift_busy, stop_done, bit_tick;
  logic dir_out, tx_permit, tx_empty;

  int checks = 0;
  int errors = 0;
  int m_st  = 0;
  int m_cnt = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  rs485_dir_ctrl #(.SETTLE_TICKS(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .rts_manual(rts_manual),
    .txq_nonempty(txq_nonempty), .shift_busy(shift_busy), .stop_done(stop_done),
    .bit_tick(bit_tick), .dir_out(dir_out), .tx_permit(tx_permit), .tx_empty(tx_empty)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_dir(int st);
    return mode_en ? (st != 0) : rts_manual;
  endfunction
  function automatic logic exp_perm(int st);
    return mode_en ? (st == 2) : 1'b1;
  endfunction
  function automatic logic exp_empty(int st);
    return !txq_nonempty && !shift_busy && (!mode_en || st == 0);
  endfunction

  // Drive at the falling edge, compare against the model, then advance the model at the rising edge.
  task automatic step(input logic en, input logic rts, input logic ne, input logic busy,
                      input logic stop, input logic tick);
    @(negedge clk);
    mode_en = en; rts_manual = rts; txq_nonempty = ne;
    shift_busy = busy; stop_done = stop; bit_tick = tick;
    #1;
    check(en ? (m_st == 0 ? "R3" : "R6") : "R2", "dir_out", dir_out, exp_dir(m_st));
    check(en ? "R5" : "R2", "tx_permit", tx_permit, exp_perm(m_st));
    check(en ? "R9" : "R2", "tx_empty", tx_empty, exp_empty(m_st));
    @(posedge clk);
    if (!en) begin
      m_st = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: begin if (ne) m_st = 1; m_cnt = 0; end
        1: if (tick) begin
             if (m_cnt == SETTLE - 1) begin m_st = 2; m_cnt = 0; end
             else m_cnt++;
           end
        default: if (stop && !ne) m_st = 0;
      endcase
    end
    #1;
  endtask

  initial begin
    #1000000;
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; mode_en = 1'b1; rts_manual = 1'b0; txq_nonempty = 1'b0;
    shift_busy = 1'b0; stop_done = 1'b0; bit_tick = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "dir_out", dir_out, 1'b0);
    check("R1", "tx_permit", tx_permit, 1'b0);
    check("R1", "tx_empty", tx_empty, 1'b1);

    // Load, settle, burst with back-to-back stop, then release.
    step(1, 0, 1, 0, 0, 0);
    check("R4", "dir_out after load", dir_out, 1'b1);
    check("R4", "tx_permit after load", tx_permit, 1'b0);
    step(1, 0, 1, 0, 0, 1);
    check("R5", "tx_permit after first tick", tx_permit, 1'b0);
    step(1, 0, 1, 0, 0, 1);
    check("R5", "tx_permit after second tick", tx_permit, 1'b1);
    step(1, 0, 0, 1, 0, 0);
    check("R6", "dir_out while shifting", dir_out, 1'b1);
    step(1, 0, 1, 1, 1, 0);
    check("R7", "dir_out on stop with data", dir_out, 1'b1);
    step(1, 0, 0, 0, 1, 0);
    check("R6", "dir_out after last stop", dir_out, 1'b0);
    check("R9", "tx_empty after release", tx_empty, 1'b1);
    step(1, 0, 1, 0, 0, 0);
    check("R8", "dir_out on reload", dir_out, 1'b1);
    check("R8", "tx_permit on reload", tx_permit, 1'b0);
    step(0, 1, 1, 0, 0, 0);
    check("R10", "dir_out follows manual", dir_out, 1'b1);
    step(1, 1, 0, 0, 0, 0);
    check("R10", "dir_out after re-enable", dir_out, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 16) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
           ($urandom % 6) == 0, ($urandom % 3) == 0);
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule